// File: doc/BRIEF.md
# Tag-Addressed Compressed Potential Store

This block holds the internal potentials of a neuron array in packed form. Only values whose validity tag is set take up a storage slot. They sit one after another with no gaps and carry no stored address. A value's logical address is recovered by walking the tag stream in ascending logical order. Each set tag consumes the next packed word, and each clear tag stands for a zero that was never stored.

The store has two packed banks that take turns. During a time slice, one bank is read in logical order through a read port. The read port is driven by a step strobe and the tag of the current logical address. The other bank is filled through a write-back port, which receives the updated values with their new tags in the same order. A slice-start strobe swaps the two banks, restarts both pointers and the logical address counter, and reports how many entries the ending slice stored. A sticky error flag records any attempt to store more entries than a bank holds, and any attempt to read past the stored entries.

Top module: `csp_store`

## Requirements
- R1: After reset, `entry_count` is 0, `err` is 0 and `rd_valid` is 0.
- R2: A write step with `wr_tag`=1 stores `wr_data` in the next free slot of the filling bank, starting at slot 0. A write step with `wr_tag`=0 takes no slot. Stored words therefore keep their arrival order with no gaps.
- R3: The cycle after `slice_start`, `entry_count` equals the number of entries stored during the slice that just ended, and the bank that was filled becomes the bank that is read.
- R4: A read step with `rd_tag`=1 makes `rd_valid`=1 and `rd_hit`=1 one cycle later. `rd_data` then holds the next unread packed word, and the read pointer advances by one.
- R5: A read step with `rd_tag`=0 makes `rd_valid`=1, `rd_hit`=0 and `rd_data`=0 one cycle later, and leaves the read pointer unchanged. The next set tag then returns the word that would have been returned before the skip.
- R6: `rd_laddr` shows the logical address of the output entry. This address counts the read steps since the last `slice_start`, and the first step is 0.
- R7: A write step with `wr_tag`=1 when the bank already holds DEPTH entries stores nothing and sets `err`. `entry_count` never exceeds DEPTH.
- R8: A read step with `rd_tag`=1 after all stored entries of the read bank are consumed returns `rd_data`=0 and sets `err`.
- R9: Once set, `err` stays 1 until reset, whatever slices and steps follow.
- R10: Write-back during a slice does not disturb the words being read in that slice. Words written in a slice are read in the next slice.
- R11: Read and write steps presented in the same cycle as `slice_start` are ignored. They produce no `rd_valid` and store nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slice_start | input | 1 | Pulse that begins a time slice and swaps the banks |
| rd_step | input | 1 | Advance one logical address on the read side |
| rd_tag | input | 1 | Validity tag of the current logical address |
| rd_valid | output | 1 | Read output entry present (one cycle after a step) |
| rd_hit | output | 1 | Output entry came from storage (tag was 1) |
| rd_data | output | VAL_W | Recovered potential, zero for a clear tag |
| rd_laddr | output | LADDR_W | Logical address of the output entry |
| wr_step | input | 1 | Present one write-back entry |
| wr_tag | input | 1 | New tag of the write-back entry |
| wr_data | input | VAL_W | Updated potential |
| entry_count | output | $clog2(DEPTH+1) | Entries stored in the last completed slice |
| err | output | 1 | Sticky capacity or read-past-end error |

## Verification
A wrong read pointer shows on the first set tag after the fault as a word out of order or a repeated word. A wrong write pointer shows as a gap or a misplaced word once the next slice reads the bank back, and as a wrong `entry_count` one cycle after the next `slice_start`. A fault in the bank swap shows as stale or clobbered data on the first hit of the following slice. A lost error shows at once on `err`, and an error that is not sticky shows on the cycle after the next slice or step.

// File: rtl/csp_pkg.sv
package csp_pkg;

    typedef enum logic [1:0] {
        STEP_IDLE = 2'd0,
        STEP_SKIP = 2'd1,
        STEP_TAKE = 2'd2
    } step_kind_e;

    typedef struct packed {
        logic valid;
        logic hit;
    } rd_flags_t;

    // Classify one port cycle; a slice boundary overrides any step.
    function automatic step_kind_e classify(input logic start,
                                            input logic step,
                                            input logic tag);
        step_kind_e k;
        if (start || !step) begin
            k = STEP_IDLE;
        end else if (tag) begin
            k = STEP_TAKE;
        end else begin
            k = STEP_SKIP;
        end
        return k;
    endfunction

endpackage

// File: rtl/csp_bank_store.sv
module csp_bank_store #(
    parameter int VAL_W = 16,
    parameter int DEPTH = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rd_bank,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [VAL_W-1:0] rd_word,
    input  logic             wr_en,
    input  logic             wr_bank,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VAL_W-1:0] wr_word
);
    localparam int N_BANKS = 2;

    logic [VAL_W-1:0] bank_word [N_BANKS];

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        logic [VAL_W-1:0] slot_q [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == b[0])) begin
                slot_q[wr_idx] <= wr_word;
            end
        end

        assign bank_word[b] = slot_q[rd_idx];
    end

    assign rd_word = bank_word[rd_bank];

endmodule

// File: rtl/csp_read_walker.sv
module csp_read_walker
    import csp_pkg::*;
#(
    parameter int VAL_W   = 16,
    parameter int DEPTH   = 16,
    parameter int LADDR_W = 8,
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               step,
    input  logic               tag,
    input  logic [CNT_W-1:0]   limit,
    input  logic [VAL_W-1:0]   mem_word,
    output logic [IDX_W-1:0]   mem_idx,
    output rd_flags_t          flags,
    output logic [VAL_W-1:0]   data,
    output logic [LADDR_W-1:0] laddr,
    output logic               past_end
);
    step_kind_e         kind;
    logic [CNT_W-1:0]   rptr_q;
    logic [LADDR_W-1:0] lcnt_q;
    logic               have_word;

    assign kind      = classify(start, step, tag);
    assign have_word = (rptr_q < limit);
    assign past_end  = (kind == STEP_TAKE) && !have_word;
    assign mem_idx   = rptr_q[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst || start) begin
            rptr_q <= '0;
            lcnt_q <= '0;
        end else begin
            if (kind == STEP_TAKE && have_word) begin
                rptr_q <= rptr_q + 1'b1;
            end
            if (kind != STEP_IDLE) begin
                lcnt_q <= lcnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            data  <= '0;
            laddr <= '0;
        end else begin
            flags.valid <= (kind != STEP_IDLE);
            flags.hit   <= (kind == STEP_TAKE);
            data        <= (kind == STEP_TAKE && have_word) ? mem_word : '0;
            if (kind != STEP_IDLE) begin
                laddr <= lcnt_q;
            end
        end
    end

    AST_RPTR_BOUND: assert property (@(posedge clk) disable iff (rst)
        rptr_q <= limit);                                                   // R8
    AST_SKIP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (step && !tag && !start) |=> $stable(rptr_q));                      // R5
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (flags.valid && !flags.hit) |-> (data == '0));                      // R5
    AST_START_QUIET: assert property (@(posedge clk) disable iff (rst)
        start |=> !flags.valid);                                            // R11

endmodule

// File: rtl/csp_write_packer.sv
module csp_write_packer
    import csp_pkg::*;
#(
    parameter int DEPTH  = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             step,
    input  logic             tag,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [CNT_W-1:0] fill,
    output logic             overflow
);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);

    step_kind_e       kind;
    logic [CNT_W-1:0] wptr_q;
    logic             full;

    assign kind     = classify(start, step, tag);
    assign full     = (wptr_q == CAP);
    assign wr_en    = (kind == STEP_TAKE) && !full;
    assign overflow = (kind == STEP_TAKE) && full;
    assign wr_idx   = wptr_q[IDX_W-1:0];
    assign fill     = wptr_q;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            wptr_q <= '0;
        end else if (wr_en) begin
            wptr_q <= wptr_q + 1'b1;
        end
    end

    AST_WPTR_BOUND: assert property (@(posedge clk) disable iff (rst)
        wptr_q <= CAP);                                                     // R7
    AST_WPTR_RESTART: assert property (@(posedge clk) disable iff (rst)
        start |=> (wptr_q == '0));                                          // R3
    AST_SKIP_NO_SLOT: assert property (@(posedge clk) disable iff (rst)
        (step && !tag && !start) |=> $stable(wptr_q));                      // R2

endmodule

// File: rtl/csp_store.sv
module csp_store
    import csp_pkg::*;
#(
    parameter int VAL_W   = 16,
    parameter int DEPTH   = 16,
    parameter int LADDR_W = 8,
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               slice_start,
    input  logic               rd_step,
    input  logic               rd_tag,
    output logic               rd_valid,
    output logic               rd_hit,
    output logic [VAL_W-1:0]   rd_data,
    output logic [LADDR_W-1:0] rd_laddr,
    input  logic               wr_step,
    input  logic               wr_tag,
    input  logic [VAL_W-1:0]   wr_data,
    output logic [CNT_W-1:0]   entry_count,
    output logic               err
);
    logic             rbank_q;
    logic [CNT_W-1:0] limit_q;
    logic [IDX_W-1:0] rd_idx;
    logic [VAL_W-1:0] rd_word;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [CNT_W-1:0] fill;
    logic             overflow;
    logic             past_end;
    rd_flags_t        flags;

    csp_bank_store #(.VAL_W(VAL_W), .DEPTH(DEPTH)) u_banks (
        .clk     (clk),
        .rd_bank (rbank_q),
        .rd_idx  (rd_idx),
        .rd_word (rd_word),
        .wr_en   (wr_en),
        .wr_bank (~rbank_q),
        .wr_idx  (wr_idx),
        .wr_word (wr_data)
    );

    csp_read_walker #(.VAL_W(VAL_W), .DEPTH(DEPTH), .LADDR_W(LADDR_W)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .start    (slice_start),
        .step     (rd_step),
        .tag      (rd_tag),
        .limit    (limit_q),
        .mem_word (rd_word),
        .mem_idx  (rd_idx),
        .flags    (flags),
        .data     (rd_data),
        .laddr    (rd_laddr),
        .past_end (past_end)
    );

    csp_write_packer #(.DEPTH(DEPTH)) u_wr (
        .clk      (clk),
        .rst      (rst),
        .start    (slice_start),
        .step     (wr_step),
        .tag      (wr_tag),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .fill     (fill),
        .overflow (overflow)
    );

    assign rd_valid = flags.valid;
    assign rd_hit   = flags.hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            rbank_q     <= 1'b0;
            limit_q     <= '0;
            entry_count <= '0;
            err         <= 1'b0;
        end else begin
            if (slice_start) begin
                rbank_q     <= ~rbank_q;
                limit_q     <= fill;
                entry_count <= fill;
            end
            if (overflow || past_end) begin
                err <= 1'b1;
            end
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err |=> err);                                                       // R9
    AST_COUNT_CAP: assert property (@(posedge clk) disable iff (rst)
        entry_count <= CNT_W'(DEPTH));                                      // R7
    AST_BANK_SWAP: assert property (@(posedge clk) disable iff (rst)
        slice_start |=> (rbank_q != $past(rbank_q)));                       // R10
    AST_COUNT_LATCH: assert property (@(posedge clk) disable iff (rst)
        slice_start |=> (entry_count == $past(fill)));                      // R3

endmodule

// File: tb/sim_csp_store.sv
module sim_csp_store;
    localparam int VAL_W = 16;
    localparam int DEPTH = 16;
    localparam int LADDR_W = 8;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic slice_start = 1'b0;
    logic rd_step = 1'b0, rd_tag = 1'b0;
    logic wr_step = 1'b0, wr_tag = 1'b0;
    logic [VAL_W-1:0] wr_data = '0;
    logic rd_valid, rd_hit, err;
    logic [VAL_W-1:0] rd_data;
    logic [LADDR_W-1:0] rd_laddr;
    logic [CNT_W-1:0] entry_count;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    csp_store #(.VAL_W(VAL_W), .DEPTH(DEPTH), .LADDR_W(LADDR_W)) u0 (
        .clk(clk), .rst(rst), .slice_start(slice_start),
        .rd_step(rd_step), .rd_tag(rd_tag), .rd_valid(rd_valid),
        .rd_hit(rd_hit), .rd_data(rd_data), .rd_laddr(rd_laddr),
        .wr_step(wr_step), .wr_tag(wr_tag), .wr_data(wr_data),
        .entry_count(entry_count), .err(err)
    );

    task automatic check(input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge; return just after the rising edge.
    task automatic cyc(input bit s, input bit rs, input bit rt,
                       input bit ws, input bit wt, input logic [VAL_W-1:0] wd);
        @(negedge clk);
        slice_start = s; rd_step = rs; rd_tag = rt;
        wr_step = ws; wr_tag = wt; wr_data = wd;
        @(posedge clk);
        #1;
        slice_start = 0; rd_step = 0; rd_tag = 0;
        wr_step = 0; wr_tag = 0; wr_data = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
    endtask

    task automatic rd_expect(input string req, input bit tag,
                             input int data, input int la);
        cyc(0, 1, tag, 0, 0, '0);
        check(req, "rd_valid", rd_valid, 1);
        check(req, "rd_hit", rd_hit, tag);
        check(req, "rd_data", rd_data, data);
        check("R6", "rd_laddr", rd_laddr, la);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1", "entry_count", entry_count, 0);
        check("R1", "err", err, 0);
        check("R1", "rd_valid", rd_valid, 0);
    endtask

    task automatic t_pack_read();
        bit tags [8] = '{1, 0, 1, 1, 0, 0, 1, 0};
        int stored [8];
        int n = 0;
        do_reset();
        cyc(1, 0, 0, 0, 0, '0);
        for (int i = 0; i < 8; i++) begin
            cyc(0, 0, 0, 1, tags[i], VAL_W'(16'hA100 + i));
            if (tags[i]) begin
                stored[n] = 16'hA100 + i;
                n++;
            end
        end
        cyc(1, 0, 0, 0, 0, '0);
        check("R3", "entry_count", entry_count, 4);
        n = 0;
        for (int i = 0; i < 8; i++) begin
            if (tags[i]) begin
                rd_expect("R4 R2", 1, stored[n], i);
                n++;
            end else begin
                rd_expect("R5", 0, 0, i);
            end
        end
        check("R8", "err after exact consumption", err, 0);
    endtask

    task automatic t_ping_pong();
        do_reset();
        cyc(1, 0, 0, 0, 0, '0);
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 1, VAL_W'(16'h5000 + i));
        cyc(1, 0, 0, 0, 0, '0);
        check("R3", "entry_count", entry_count, 3);
        // read old words while writing new ones into the other bank
        for (int i = 0; i < 3; i++) begin
            cyc(0, 0, 0, 1, 1, VAL_W'(16'h7700 + i));
            rd_expect("R10", 1, 16'h5000 + i, i);
        end
        cyc(1, 0, 0, 0, 0, '0);
        check("R10", "entry_count", entry_count, 3);
        rd_expect("R10", 0, 0, 0);
        rd_expect("R10", 1, 16'h7700, 1);
        rd_expect("R10", 1, 16'h7701, 2);
        rd_expect("R10", 1, 16'h7702, 3);
        cyc(1, 0, 0, 0, 0, '0);
        check("R3", "empty slice count", entry_count, 0);
    endtask

    task automatic t_start_ignored();
        do_reset();
        cyc(1, 0, 0, 0, 0, '0);
        cyc(1, 1, 1, 1, 1, 16'hBEEF);
        check("R11", "rd_valid on start", rd_valid, 0);
        cyc(1, 0, 0, 0, 0, '0);
        check("R11", "entry_count", entry_count, 0);
        check("R11", "err", err, 0);
    endtask

    task automatic t_overflow();
        do_reset();
        cyc(1, 0, 0, 0, 0, '0);
        for (int i = 0; i < DEPTH; i++) cyc(0, 0, 0, 1, 1, VAL_W'(16'hC000 + i));
        check("R7", "err at capacity", err, 0);
        cyc(0, 0, 0, 1, 1, 16'hDEAD);
        check("R7", "err after overflow", err, 1);
        cyc(1, 0, 0, 0, 0, '0);
        check("R7", "entry_count", entry_count, DEPTH);
        for (int i = 0; i < DEPTH; i++) rd_expect("R7", 1, 16'hC000 + i, i);
        cyc(1, 0, 0, 0, 0, '0);
        cyc(0, 0, 0, 1, 0, '0);
        cyc(1, 0, 0, 0, 0, '0);
        check("R9", "err after slices", err, 1);
        do_reset();
        check("R1", "err cleared by reset", err, 0);
    endtask

    task automatic t_read_past();
        do_reset();
        cyc(1, 0, 0, 0, 0, '0);
        cyc(0, 0, 0, 1, 1, 16'h1234);
        cyc(1, 0, 0, 0, 0, '0);
        rd_expect("R8", 1, 16'h1234, 0);
        check("R8", "err before past end", err, 0);
        rd_expect("R8", 1, 0, 1);
        check("R8", "err past end", err, 1);
        cyc(1, 0, 0, 0, 0, '0);
        rd_expect("R9", 0, 0, 0);
        check("R9", "err sticky", err, 1);
    endtask

    initial begin
        t_reset();
        t_pack_read();
        t_ping_pong();
        t_start_ignored();
        t_overflow();
        t_read_past();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule